// File: doc/BRIEF.md
# Clock Generator Control Register Slave

This block is the two-wire control port of a clock generator. A host on an SMBus/I2C-style bus reads and writes a bank of eight 8-bit control registers. The bus lines arrive as plain inputs sampled by the fast system clock. SDA is driven through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. The slave never stretches the clock.

Every transaction begins with the write address and a command byte. Bit 7 of the command chooses between two modes. In single-register mode, bits 4:0 name an offset. In block mode, transfers start at offset zero: a block write carries a byte count ahead of its data, and a block read returns a count ahead of its data. Reads use a repeated start followed by the read address. The register contents drive the output-enable, spread-spectrum and test-mode controls of the clock generator as parallel outputs. Register 7 is a fixed identification byte.

Top module: `clkgen_smbus_regs`

## Requirements
- R1: The slave acknowledges only the 7-bit address 1101001 (write byte D2h, read byte D3h). Any other address gets no acknowledge, `sda_oe` stays low, and no register changes.
- R2: All bytes travel most significant bit first. An accepted byte is acknowledged by raising `sda_oe` while SCL is low, for the ninth clock.
- R3: Command bits 6:5 must be 00 or the command byte is not acknowledged and the transaction is dropped. Bit 7 = 1 selects single-register mode, with the offset in bits 4:0. Bit 7 = 0 selects block mode.
- R4: A single-register write stores the data byte at the given offset. A single-register read (command, repeated start, D3h) returns the register at that offset, and the host's NACK ends it.
- R5: A block write takes a count byte and then stores its data bytes at offsets 0, 1, 2 and upward. A stop after any complete byte keeps the bytes already received.
- R6: A block read returns the count byte 08h and then the registers from offset 0 upward. It continues for as long as the host acknowledges.
- R7: After reset the registers hold, for offsets 0 to 7: 7Ch, 00h, EBh, AFh, 01h, 00h, 13h, 38h.
- R8: Register 7 always reads 38h. Writes to it are acknowledged and have no effect.
- R9: Offsets 8 and above read as 00h. Writes to them are acknowledged and discarded.
- R10: A start or stop in the middle of a received byte returns the slave to idle, and no register changes. A stop always releases `sda_oe`.
- R11: The outputs map as follows: `out_en` = register 0 bits 6:2 (0 = output in high impedance), `ss_depth_sel` = register 2 bit 7, `ss_enable` = register 2 bit 2, `test_mode` = register 6 bit 6, `test_ref_sel` = register 6 bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| out_en | output | 5 | Per-output enables of the differential clocks |
| ss_depth_sel | output | 1 | Spread depth: 0 = -0.35 %, 1 = -0.50 % |
| ss_enable | output | 1 | Spread modulation on |
| test_mode | output | 1 | Test clock mode entry |
| test_ref_sel | output | 1 | In test mode: 1 = divided reference, 0 = tri-state |

## Verification
The bench builds the block with its default parameters: device address 69h, eight registers, two synchronizer stages and a 6-bit register pointer. With these values it can sweep all 128 bus addresses, every register offset in both single-register modes, and block reads that run past the last register into the zero-filled range. Expected register contents come from a model in the bench that starts at the reset values and is updated by each write the requirements allow.

// File: rtl/clkgen_smbus_pkg.sv
// Shared types and reset values for the clock-generator control slave.
package clkgen_smbus_pkg;

    // Bus engine states: receive a byte, ack it, transmit a byte, take the host ack.
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RX_END, ST_ACK, ST_TX, ST_HACK, ST_HACK_END
    } smb_state_t;

    // Meaning of the next byte the host writes.
    typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_COUNT, PH_DATA} smb_phase_t;

    // Power-up value of each control register.
    function automatic logic [7:0] ctl_default(input int idx);
        case (idx)
            0:       return 8'h7C;
            2:       return 8'hEB;
            3:       return 8'hAF;
            4:       return 8'h01;
            6:       return 8'h13;
            7:       return 8'h38;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL and SDA into the clk domain through a flop chain. Also gives the
// previous synchronized sample, for edge detection.
// Assumes STAGES >= 2. Both lines reset to the idle (high) level.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_q,
    output logic sda_q
);
    logic [STAGES-1:0] scl_ff, sda_ff;

    // Shift the pad levels through the chain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];
endmodule

// File: rtl/clkgen_reg_bank.sv
// Control register bank. One write port and one combinational read port.
// Offsets at or beyond NUM_REGS read as zero and ignore writes. Register
// RO_IDX is a constant. Assumes NUM_REGS >= 7 so that the control fields exist.
module clkgen_reg_bank
    import clkgen_smbus_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int AW       = 6,
    parameter int RO_IDX   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [4:0]    out_en,
    output logic          ss_depth_sel,
    output logic          ss_enable,
    output logic          test_mode,
    output logic          test_ref_sel
);
    localparam int IW = $clog2(NUM_REGS);

    logic [7:0] mem [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == RO_IDX) begin : g_ro
            assign mem[i] = ctl_default(i);
        end else begin : g_rw
            // Load the reset value, then take writes aimed at this offset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[i] <= ctl_default(i);
                else if (wr_en && wr_addr == AW'(i))
                    mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = (rd_addr < AW'(NUM_REGS)) ? mem[rd_addr[IW-1:0]] : 8'h00;

    assign out_en       = mem[0][6:2];
    assign ss_depth_sel = mem[2][7];
    assign ss_enable    = mem[2][2];
    assign test_mode    = mem[6][6];
    assign test_ref_sel = mem[6][7];
endmodule

// File: rtl/smb_slave_fsm.sv
// Byte-level SMBus slave engine. Works on synchronized line samples: it
// detects start, stop and SCL edges, shifts bytes MSB first, decodes the
// address and command bytes, and runs single-register and block transfers.
// Assumes the host keeps each SCL level for several clk cycles. A start that
// comes after at most one SCL rise of a byte counts as a repeated start.
module smb_slave_fsm
    import clkgen_smbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 8,
    parameter int         AW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          scl_q,
    input  logic          sda_s,
    input  logic          sda_q,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          stop_det
);
    smb_state_t    state;
    smb_phase_t    phase;
    logic [3:0]    cnt;
    logic [6:0]    rx_sh, tx_sh;
    logic [AW-1:0] ptr;
    logic          have_cmd, blk_mode, ack_ok, go_tx, send_count, more, sda_low;

    logic       rise, fall, start_det, last_rise, boundary;
    logic [7:0] byte_in, tx_byte;

    assign rise      = scl_s & ~scl_q;
    assign fall      = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    assign byte_in   = {rx_sh, sda_s};
    assign last_rise = (state == ST_RX) && rise && (cnt == 4'd7);
    assign boundary  = (state == ST_RX) && (cnt <= 4'd1);
    assign tx_byte   = send_count ? 8'(NUM_REGS) : rd_data;

    assign wr_en   = last_rise && (phase == PH_DATA);
    assign wr_addr = ptr;
    assign wr_data = byte_in;
    assign rd_addr = ptr;
    assign sda_oe  = sda_low;
    assign busy    = (state != ST_IDLE);

    // Advance the transaction on bus conditions and SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;   phase <= PH_ADDR;  cnt <= '0;
            rx_sh <= '0;        tx_sh <= '0;       ptr <= '0;
            have_cmd <= 1'b0;   blk_mode <= 1'b0;  ack_ok <= 1'b0;
            go_tx <= 1'b0;      send_count <= 1'b0; more <= 1'b0;
            sda_low <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
        end else if (start_det) begin
            sda_low <= 1'b0;
            cnt     <= '0;
            phase   <= PH_ADDR;
            if (state == ST_IDLE) begin
                state    <= ST_RX;
                have_cmd <= 1'b0;
            end else if (boundary) begin
                state <= ST_RX;
            end else begin
                state <= ST_IDLE;
            end
        end else begin
            case (state)
                ST_RX: if (rise) begin
                    rx_sh <= byte_in[6:0];
                    cnt   <= cnt + 4'd1;
                    if (cnt == 4'd7) begin
                        state <= ST_RX_END;
                        go_tx <= 1'b0;
                        case (phase)
                            PH_ADDR: begin
                                ack_ok     <= (byte_in[7:1] == DEV_ADDR) && (!byte_in[0] || have_cmd);
                                go_tx      <= byte_in[0];
                                send_count <= blk_mode;
                                if (!byte_in[0]) phase <= PH_CMD;
                            end
                            PH_CMD: begin
                                ack_ok   <= (byte_in[6:5] == 2'b00);
                                have_cmd <= (byte_in[6:5] == 2'b00);
                                blk_mode <= ~byte_in[7];
                                ptr      <= byte_in[7] ? AW'(byte_in[4:0]) : '0;
                                phase    <= byte_in[7] ? PH_DATA : PH_COUNT;
                            end
                            PH_COUNT: begin
                                ack_ok <= 1'b1;
                                phase  <= PH_DATA;
                            end
                            default: begin
                                ack_ok <= 1'b1;
                                if (ptr != '1) ptr <= ptr + 1'b1;
                            end
                        endcase
                    end
                end
                ST_RX_END: if (fall) begin
                    sda_low <= ack_ok;
                    state   <= ack_ok ? ST_ACK : ST_IDLE;
                end
                ST_ACK: if (fall) begin
                    cnt <= '0;
                    if (go_tx) begin
                        sda_low    <= ~tx_byte[7];
                        tx_sh      <= tx_byte[6:0];
                        send_count <= 1'b0;
                        if (!send_count && ptr != '1) ptr <= ptr + 1'b1;
                        state      <= ST_TX;
                    end else begin
                        sda_low <= 1'b0;
                        state   <= ST_RX;
                    end
                end
                ST_TX: begin
                    if (rise) cnt <= cnt + 4'd1;
                    if (fall) begin
                        if (cnt == 4'd8) begin
                            sda_low <= 1'b0;
                            state   <= ST_HACK;
                        end else begin
                            sda_low <= ~tx_sh[6];
                            tx_sh   <= {tx_sh[5:0], 1'b0};
                        end
                    end
                end
                ST_HACK: if (rise) begin
                    more  <= ~sda_s;
                    state <= ST_HACK_END;
                end
                ST_HACK_END: if (fall) begin
                    cnt <= '0;
                    if (more) begin
                        sda_low    <= ~tx_byte[7];
                        tx_sh      <= tx_byte[6:0];
                        send_count <= 1'b0;
                        if (!send_count && ptr != '1) ptr <= ptr + 1'b1;
                        state      <= ST_TX;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/clkgen_smbus_regs.sv
// Top of the clock-generator control slave: line synchronizer, bus engine
// and register bank. The pad logic outside forms an open drain from sda_oe
// and feeds the wired line level back on sda_i.
module clkgen_smbus_regs #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2,
    parameter int         PTR_W       = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [4:0] out_en,
    output logic       ss_depth_sel,
    output logic       ss_enable,
    output logic       test_mode,
    output logic       test_ref_sel
);
    logic             scl_s, sda_s, scl_q, sda_q;
    logic             wr_en, busy, stop_det;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic [7:0]       wr_data, rd_data;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_q(scl_q), .sda_q(sda_q)
    );

    smb_slave_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .AW(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q),
        .sda_s(sda_s), .sda_q(sda_q), .rd_data(rd_data), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .busy(busy), .stop_det(stop_det)
    );

    clkgen_reg_bank #(.NUM_REGS(NUM_REGS), .AW(PTR_W), .RO_IDX(7)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_en(out_en), .ss_depth_sel(ss_depth_sel), .ss_enable(ss_enable),
        .test_mode(test_mode), .test_ref_sel(test_ref_sel)
    );
endmodule

// File: rtl/clkgen_smbus_regs_chk.sv
// Protocol checker for clkgen_smbus_regs. It relates the bus drive, the
// synchronized SCL, the engine state and the control outputs over time.
module clkgen_smbus_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       scl_q,
    input logic       stop_det,
    input logic       wr_en,
    input logic       busy,
    input logic [4:0] out_en,
    input logic       ss_depth_sel,
    input logic       ss_enable,
    input logic       test_mode,
    input logic       test_ref_sel
);
    AST_DRIVE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> busy);                                                   // R1
    AST_DRIVE_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_q);                                          // R2
    AST_WRITE_ON_SCL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (scl_s && !scl_q));                                       // R4
    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_en == 5'h1F && ss_depth_sel && !ss_enable
                          && !test_mode && !test_ref_sel));                 // R7
    AST_STOP_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);                                              // R10
    AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy);                                                // R10
endmodule

bind clkgen_smbus_regs clkgen_smbus_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .scl_q(scl_q),
    .stop_det(stop_det), .wr_en(wr_en), .busy(busy), .out_en(out_en),
    .ss_depth_sel(ss_depth_sel), .ss_enable(ss_enable), .test_mode(test_mode),
    .test_ref_sel(test_ref_sel)
);

// File: tb/clkgen_smbus_regs_tb.sv
`timescale 1ns/1ps
// Bus-level bench: a host model drives SCL/SDA and keeps a register model.
module clkgen_smbus_regs_tb_top;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe, ss_depth_sel, ss_enable, test_mode, test_ref_sel;
    logic [4:0] out_en;
    wire sda_bus = sda_h & ~sda_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [0:7];
    logic [7:0] rbuf [0:15];

    always #2.5 clk = ~clk;

    clkgen_smbus_regs dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .out_en(out_en), .ss_depth_sel(ss_depth_sel), .ss_enable(ss_enable),
        .test_mode(test_mode), .test_ref_sel(test_ref_sel)
    );

    function automatic logic [7:0] reset_val(input int i);
        case (i)
            0: return 8'h7C; 2: return 8'hEB; 3: return 8'hAF; 4: return 8'h01;
            6: return 8'h13; 7: return 8'h38; default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hold(Q); scl = 1'b1; hold(Q); sda_h = 1'b0; hold(Q); scl = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_h = 1'b1; hold(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; hold(Q); scl = 1'b1; hold(Q); b = sda_bus; hold(Q); scl = 1'b0; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic host_ack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        send_bit(~host_ack);
    endtask

    task automatic wr_single(input logic [7:0] cmd, input logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        bus_start(); send_byte(8'hD2, a0); send_byte(cmd, a1); send_byte(d, a2); bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic rd_single(input logic [7:0] off, output logic [7:0] v, output logic ok);
        logic a0, a1, a2;
        bus_start(); send_byte(8'hD2, a0); send_byte(8'h80 | off, a1);
        bus_start(); send_byte(8'hD3, a2); get_byte(v, 1'b0); bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic wr_block(input int n, input int base, input int step, output logic ok);
        logic a;
        ok = 1'b1;
        bus_start(); send_byte(8'hD2, a); ok &= a; send_byte(8'h00, a); ok &= a;
        send_byte(8'(n), a); ok &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(8'(base + i*step), a); ok &= a;
        end
        bus_stop();
    endtask

    // rbuf[0] = count byte, rbuf[1..n] = data bytes.
    task automatic rd_block(input int n, output logic ok);
        logic a0, a1, a2;
        logic [7:0] v;
        bus_start(); send_byte(8'hD2, a0); send_byte(8'h00, a1);
        bus_start(); send_byte(8'hD3, a2);
        get_byte(v, 1'b1); rbuf[0] = v;
        for (int i = 1; i <= n; i++) begin
            get_byte(v, i != n); rbuf[i] = v;
        end
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic check_ports(input string req);
        check({req, " out_en"}, 32'(out_en), 32'(model[0][6:2]));
        check({req, " ss_depth_sel"}, 32'(ss_depth_sel), 32'(model[2][7]));
        check({req, " ss_enable"}, 32'(ss_enable), 32'(model[2][2]));
        check({req, " test_mode"}, 32'(test_mode), 32'(model[6][6]));
        check({req, " test_ref_sel"}, 32'(test_ref_sel), 32'(model[6][7]));
    endtask

    task automatic check_all_regs(input string req);
        logic ok;
        rd_block(8, ok);
        check({req, " block read ack"}, 32'(ok), 32'd1);
        for (int i = 0; i < 8; i++) check({req, " reg readback"}, 32'(rbuf[i+1]), 32'(model[i]));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        hold(170000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        logic ok, a;
        logic [7:0] v;
        for (int i = 0; i < 8; i++) model[i] = reset_val(i);
        hold(5); rst_n = 1'b1; hold(5);

        // R7, R11: reset state at the ports; R1: no drive while idle
        check_ports("R7 R11 reset");
        check("R1 idle sda_oe", 32'(sda_oe), 32'd0);

        // R4 R7 R8: single-register read sweep of the reset values
        for (int i = 0; i < 8; i++) begin
            rd_single(8'(i), v, ok);
            check("R2 R4 read acks", 32'(ok), 32'd1);
            check("R7 reset value", 32'(v), 32'(model[i]));
        end

        // R6: block read of count and all registers
        rd_block(8, ok);
        check("R6 block read acks", 32'(ok), 32'd1);
        check("R6 count byte", 32'(rbuf[0]), 32'h08);
        for (int i = 0; i < 8; i++) check("R6 block data", 32'(rbuf[i+1]), 32'(model[i]));

        // R4 R8: single-register write sweep, register 7 keeps its value
        for (int i = 0; i < 8; i++) begin
            v = 8'(i*53 + 17);
            wr_single(8'h80 | 8'(i), v, ok);
            check("R4 R8 write acks", 32'(ok), 32'd1);
            if (i != 7) model[i] = v;
        end
        for (int i = 0; i < 8; i++) begin
            rd_single(8'(i), v, ok);
            check("R4 R8 readback", 32'(v), 32'(model[i]));
        end
        check_ports("R11 after single writes");

        // R5: full block write, then a write stopped after three bytes
        wr_block(8, 200, 29, ok);
        check("R5 block write acks", 32'(ok), 32'd1);
        for (int i = 0; i < 7; i++) model[i] = 8'(200 + i*29);
        check_all_regs("R5 full block");
        check_ports("R11 after block write");
        wr_block(3, 8'hA5, 1, ok);
        check("R5 partial acks", 32'(ok), 32'd1);
        for (int i = 0; i < 3; i++) model[i] = 8'(8'hA5 + i);
        check_all_regs("R5 partial block");
        check_ports("R11 after partial block");

        // R9: beyond the last register
        wr_single(8'h80 | 8'd20, 8'h5A, ok);
        check("R9 out-of-range write ack", 32'(ok), 32'd1);
        rd_single(8'd20, v, ok);
        check("R9 out-of-range read", 32'(v), 32'h00);
        rd_block(10, ok);
        check("R9 R6 block count", 32'(rbuf[0]), 32'h08);
        for (int i = 0; i < 8; i++) check("R9 R6 block data", 32'(rbuf[i+1]), 32'(model[i]));
        check("R9 past end 8", 32'(rbuf[9]), 32'h00);
        check("R9 past end 9", 32'(rbuf[10]), 32'h00);

        // R3: chip-select field not 00 is refused, register untouched
        bus_start(); send_byte(8'hD2, a); send_byte(8'hA2, ok); send_byte(8'h00, a); bus_stop();
        check("R3 nonzero chip select nack", 32'(ok), 32'd0);
        rd_single(8'd2, v, ok);
        check("R3 register unchanged", 32'(v), 32'(model[2]));

        // R1: every other address is ignored
        for (int ad = 0; ad < 128; ad++) begin
            if (ad != 7'h69) begin
                bus_start(); send_byte({7'(ad), 1'b0}, a); bus_stop();
                check("R1 foreign address nack", 32'(a), 32'd0);
            end
        end
        bus_start(); send_byte(8'hD0, a); send_byte(8'h82, a); send_byte(8'h00, a); bus_stop();
        check_all_regs("R1 no effect");

        // R10: start and stop in the middle of a data byte
        bus_start(); send_byte(8'hD2, a); send_byte(8'h82, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start(); send_byte(8'hD2, a); bus_stop();
        check("R10 idle after mid-byte start", 32'(a), 32'd0);
        check("R10 sda released", 32'(sda_oe), 32'd0);
        bus_start(); send_byte(8'hD2, a); send_byte(8'h82, a);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_stop();
        check_all_regs("R10 no change");
        check_ports("R10 R11 ports unchanged");

        done = 1'b1;
        finish_run();
    end
endmodule